// File: doc/BRIEF.md
# Redistributor Frame Address Decoder

This block sits behind the register bus of an interrupt controller that gives each processor its own redistributor. Every incoming access address is classified. The first test is against a fixed distributor window. The second is against a redistributor window whose length grows with the number of processors currently online. For a redistributor access the block works out which processor's frame was hit. That comes from the address itself, not from whichever processor issued the access. It also works out which half of that frame was addressed: the lower 64 KiB control half, or the upper 64 KiB private-interrupt half.

Each processor owns a 128 KiB frame. The block answers the fixed, read-only registers of both halves itself. These include a type register carrying the processor number, a last-processor flag and the processor's packed affinity. Enable, pending, priority and configuration offsets of the private half are only routed: the block marks them as not owned so that storage elsewhere answers them. Requests enter on a valid/ready channel, and each accepted request produces exactly one response on a second valid/ready channel one cycle later. The response is held while the consumer stalls, and no new request is taken until the held response drains.

Top module: `rdist_frame_decoder`

## Requirements
- R1: An address in [DIST_BASE, DIST_BASE+DIST_SIZE) responds with target 1 (distributor), owned 0, cpu 0 and data 0. This test is applied before the redistributor test.
- R2: An address outside both windows responds with target 0 (unclaimed), owned 0, cpu 0 and data 0.
- R3: The redistributor window is [RDIST_BASE, RDIST_BASE + n*128 KiB), where n is online_cnt clamped to MAX_CPUS. Addresses at or beyond the last online frame are unclaimed.
- R4: For a redistributor hit, the response cpu equals (address - RDIST_BASE) / 128 KiB.
- R5: Within a frame, offset bit 16 set gives target 3 (private-interrupt half); clear gives target 2 (control half).
- R6: Control offset 0x0008 (type, low word) reads as cpu shifted left by 8, with bit 4 set only when cpu equals n-1.
- R7: Control offset 0x000C (type, high word) reads the affinity bytes of that processor's 40-bit identity as {id[39:32], id[23:16], id[15:8], id[7:0]}.
- R8: Control offsets 0x0000 and 0x0014 read as zero. Every write response carries zero data and leaves every later read unchanged.
- R9: Control offset 0x0004 reads IDENT_VALUE. Offset 0xFFE8 reads 0x3B. The other words of 0xFFD0..0xFFFC read zero.
- R10: Private offset 0x0080 reads 0xFFFFFFFF. Private offsets 0x0300, 0x0380, 0x0D00 and 0x0E00 read zero with owned 1.
- R11: Private offsets 0x0100, 0x0180, 0x0200, 0x0280, 0x0400..0x041F and 0x0C00..0x0C07 respond with owned 0 and data 0.
- R12: Any other offset in either half responds with owned 1 and data 0. Word selection ignores address bits 1:0.
- R13: req_ready is high when no response is held or rsp_ready is high. An accepted request yields rsp_valid on the next cycle. A response is held unchanged while rsp_valid is high and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | CNT_W | Number of online processors |
| cpu_ident | input | MAX_CPUS*40 | Per-processor 40-bit identity, packed, processor 0 in the low slot |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_target | output | 2 | 0 unclaimed, 1 distributor, 2 control half, 3 private half |
| rsp_cpu | output | IDX_W | Target processor index |
| rsp_owned | output | 1 | This block supplied rsp_rdata |
| rsp_rdata | output | 32 | Read data |

## Verification
The stimulus covers several kinds of address:
- Addresses at both edges of each window, which separate off-by-one errors in the window comparisons.
- The same register offsets on every online processor, which shows that the index and the last flag follow the address.
- Offsets straddling the private storage ranges and the 64 KiB half boundary, which separate a routing error from a data error.

The online count is swept through a middle value, zero and a value above the processor limit, which exposes a missing clamp or a stale last flag. A stretch of back-to-back traffic under random consumer stalls checks that responses are neither lost, duplicated nor changed while held.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  typedef enum logic [1:0] {
    TGT_NONE    = 2'd0,
    TGT_DIST    = 2'd1,
    TGT_RD_CTRL = 2'd2,
    TGT_RD_PRIV = 2'd3
  } tgt_e;

  // frame geometry: 128 KiB per processor, split into two 64 KiB halves
  localparam int FRAME_SHIFT = 17;
  localparam int HALF_SHIFT  = 16;

  // control-half word offsets
  localparam logic [15:0] OFS_CTL     = 16'h0000;
  localparam logic [15:0] OFS_IDENT   = 16'h0004;
  localparam logic [15:0] OFS_TYPE_LO = 16'h0008;
  localparam logic [15:0] OFS_TYPE_HI = 16'h000C;
  localparam logic [15:0] OFS_WAKE    = 16'h0014;
  localparam logic [15:0] OFS_PERIPH2 = 16'hFFE8;
  localparam logic [31:0] PERIPH2_VAL = 32'h0000_003B;

  // type register field positions
  localparam int TYPE_LAST_BIT = 4;
  localparam int TYPE_CPU_LSB  = 8;

  // private-half word offsets
  localparam logic [15:0] OFS_GROUP = 16'h0080;

  function automatic logic [31:0] pack_affinity(input logic [7:0] a3, input logic [23:0] a210);
    return {a3, a210};
  endfunction

  // offsets whose storage lives outside this block
  function automatic logic is_priv_storage(input logic [15:0] ow);
    logic hit;
    hit = (ow == 16'h0100) || (ow == 16'h0180) ||
          (ow == 16'h0200) || (ow == 16'h0280) ||
          ((ow >= 16'h0400) && (ow < 16'h0420)) ||
          ((ow >= 16'h0C00) && (ow < 16'h0C08));
    return hit;
  endfunction

endpackage

// File: rtl/rdec_window.sv
module rdec_window
  import rdec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_CPUS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 4,
  parameter logic [ADDR_W-1:0] DIST_BASE  = 'h0800_0000,
  parameter logic [ADDR_W-1:0] DIST_SIZE  = 'h0001_0000,
  parameter logic [ADDR_W-1:0] RDIST_BASE = 'h080A_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  online_eff,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  cpu,
  output logic [15:0]       ofs
);

  logic [ADDR_W-1:0] dist_off;
  logic [ADDR_W-1:0] rd_off;
  logic [ADDR_W-1:0] frame_no;
  logic              in_dist;
  logic              in_rd;

  always_comb begin
    dist_off = addr - DIST_BASE;
    rd_off   = addr - RDIST_BASE;
    frame_no = rd_off >> FRAME_SHIFT;
    in_dist  = (addr >= DIST_BASE) && (dist_off < DIST_SIZE);
    in_rd    = (addr >= RDIST_BASE) && (frame_no < ADDR_W'(online_eff));
    tgt = TGT_NONE;
    cpu = '0;
    ofs = '0;
    if (in_dist) begin
      tgt = TGT_DIST;
    end else if (in_rd) begin
      tgt = rd_off[HALF_SHIFT] ? TGT_RD_PRIV : TGT_RD_CTRL;
      cpu = frame_no[IDX_W-1:0];
      ofs = rd_off[15:0];
    end
  end

endmodule

// File: rtl/rdec_regs.sv
module rdec_regs
  import rdec_pkg::*;
#(
  parameter int MAX_CPUS = 8,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 4,
  parameter logic [31:0] IDENT_VALUE = 32'h0100_0A5C
) (
  input  tgt_e                       tgt,
  input  logic [IDX_W-1:0]           cpu,
  input  logic [15:0]                ofs,
  input  logic                       write,
  input  logic [CNT_W-1:0]           online_eff,
  input  logic [MAX_CPUS-1:0][39:0]  cpu_ident,
  output logic                       owned,
  output logic [31:0]                rdata
);

  logic [MAX_CPUS-1:0][31:0] aff_pk;
  logic [MAX_CPUS-1:0]       unused_ident;

  for (genvar g = 0; g < MAX_CPUS; g++) begin : g_aff
    assign aff_pk[g]       = pack_affinity(cpu_ident[g][39:32], cpu_ident[g][23:0]);
    assign unused_ident[g] = ^cpu_ident[g][31:24];
  end

  logic [15:0] ow;
  logic        is_last;
  logic        unused_low;
  logic [31:0] rd_val;

  assign ow         = {ofs[15:2], 2'b00};
  assign unused_low = ^{ofs[1:0], unused_ident};
  assign is_last    = ((int'(cpu) + 1) == int'(online_eff));

  always_comb begin
    owned  = 1'b0;
    rd_val = '0;
    unique case (tgt)
      TGT_RD_CTRL: begin
        owned = 1'b1;
        if (ow == OFS_IDENT)        rd_val = IDENT_VALUE;
        else if (ow == OFS_TYPE_LO) begin
          rd_val = 32'(cpu) << TYPE_CPU_LSB;
          rd_val[TYPE_LAST_BIT] = is_last;
        end
        else if (ow == OFS_TYPE_HI) rd_val = aff_pk[cpu];
        else if (ow == OFS_PERIPH2) rd_val = PERIPH2_VAL;
        else                        rd_val = '0;  // control, wake, other id words, holes
      end
      TGT_RD_PRIV: begin
        owned = !is_priv_storage(ow);
        if (ow == OFS_GROUP) rd_val = '1;
        else                 rd_val = '0;
      end
      default: begin
        owned  = 1'b0;
        rd_val = '0;
      end
    endcase
    rdata = write ? '0 : rd_val;
  end

endmodule

// File: rtl/rdec_rsp_stage.sv
module rdec_rsp_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/rdist_frame_decoder.sv
module rdist_frame_decoder
  import rdec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_CPUS = 8,
  parameter logic [ADDR_W-1:0] DIST_BASE  = 'h0800_0000,
  parameter logic [ADDR_W-1:0] DIST_SIZE  = 'h0001_0000,
  parameter logic [ADDR_W-1:0] RDIST_BASE = 'h080A_0000,
  parameter logic [31:0] IDENT_VALUE = 32'h0100_0A5C,
  localparam int IDX_W = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W = $clog2(MAX_CPUS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          online_cnt,
  input  logic [MAX_CPUS-1:0][39:0] cpu_ident,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [1:0]                rsp_target,
  output logic [IDX_W-1:0]          rsp_cpu,
  output logic                      rsp_owned,
  output logic [31:0]               rsp_rdata
);

  localparam int PAY_W = 2 + IDX_W + 1 + 32;

  logic [CNT_W-1:0] online_eff;
  assign online_eff = (int'(online_cnt) > MAX_CPUS) ? CNT_W'(MAX_CPUS) : online_cnt;

  tgt_e             w_tgt;
  logic [IDX_W-1:0] w_cpu;
  logic [15:0]      w_ofs;
  logic             r_owned;
  logic [31:0]      r_data;

  rdec_window #(
    .ADDR_W(ADDR_W), .MAX_CPUS(MAX_CPUS), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .DIST_BASE(DIST_BASE), .DIST_SIZE(DIST_SIZE), .RDIST_BASE(RDIST_BASE)
  ) u_window (
    .addr(req_addr), .online_eff(online_eff),
    .tgt(w_tgt), .cpu(w_cpu), .ofs(w_ofs)
  );

  rdec_regs #(
    .MAX_CPUS(MAX_CPUS), .IDX_W(IDX_W), .CNT_W(CNT_W), .IDENT_VALUE(IDENT_VALUE)
  ) u_regs (
    .tgt(w_tgt), .cpu(w_cpu), .ofs(w_ofs), .write(req_write),
    .online_eff(online_eff), .cpu_ident(cpu_ident),
    .owned(r_owned), .rdata(r_data)
  );

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign pay_in = {w_tgt, w_cpu, r_owned, r_data};

  rdec_rsp_stage #(.PAY_W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_target, rsp_cpu, rsp_owned, rsp_rdata} = pay_out;

endmodule

// File: rtl/rdist_frame_decoder_chk.sv
module rdist_frame_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] DIST_BASE = 'h0800_0000,
  parameter logic [ADDR_W-1:0] DIST_SIZE = 'h0001_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_target,
  input logic [IDX_W-1:0]  rsp_cpu,
  input logic              rsp_owned,
  input logic [31:0]       rsp_rdata
);

  logic take;
  logic in_dist_w;
  assign take      = req_valid && req_ready;
  assign in_dist_w = (req_addr >= DIST_BASE) && ((req_addr - DIST_BASE) < DIST_SIZE);

  // R13
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_target)
                                   && $stable(rsp_cpu) && $stable(rsp_owned)));

  // R2
  unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 2'd0) |-> (rsp_rdata == 32'd0 && rsp_cpu == '0 && !rsp_owned));

  // R1
  dist_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_dist_w) |=> (rsp_target == 2'd1 && !rsp_owned && rsp_rdata == 32'd0));

  // R8
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write) |=> (rsp_rdata == 32'd0));

endmodule

bind rdist_frame_decoder rdist_frame_decoder_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DIST_BASE(DIST_BASE), .DIST_SIZE(DIST_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_target(rsp_target), .rsp_cpu(rsp_cpu),
  .rsp_owned(rsp_owned), .rsp_rdata(rsp_rdata)
);

// File: tb/rdist_frame_decoder_test.sv
module rdist_frame_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXC  = 8;
  localparam int IDXW  = 3;
  localparam int CNTW  = 4;
  localparam longint DB = 64'h0800_0000;
  localparam longint DS = 64'h0001_0000;
  localparam longint RB = 64'h080A_0000;
  localparam longint FR = 131072;
  localparam logic [31:0] IDENT = 32'h0100_0A5C;

  logic clk = 0;
  logic rst_n = 0;
  logic [CNTW-1:0] online_cnt = 4;
  logic [MAXC-1:0][39:0] cpu_ident;
  logic req_valid = 0;
  logic req_ready;
  logic [31:0] req_addr = 0;
  logic req_write = 0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [1:0] rsp_target;
  logic [IDXW-1:0] rsp_cpu;
  logic rsp_owned;
  logic [31:0] rsp_rdata;

  int vectors = 0;
  int fails = 0;
  bit stall_mode = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdist_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt), .cpu_ident(cpu_ident),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
    .rsp_cpu(rsp_cpu), .rsp_owned(rsp_owned), .rsp_rdata(rsp_rdata)
  );

  // behavioural reference of one access
  function automatic void model(input logic [31:0] a_in, input bit wr, input int online,
                                output int tgt, output int cpu, output bit own,
                                output logic [31:0] d, output string ttag, output string dtag);
    longint a = longint'(a_in);
    int n = (online > MAXC) ? MAXC : online;
    tgt = 0; cpu = 0; own = 0; d = 0; ttag = "R2"; dtag = "R2";
    if (a >= DB && a < DB + DS) begin
      tgt = 1; ttag = "R1"; dtag = "R1";
    end else if (a >= RB && a < RB + longint'(n) * FR) begin
      longint o = (a - RB) % FR;
      longint fo = (o % 65536) / 4 * 4;
      cpu = int'((a - RB) / FR);
      ttag = "R5";
      if (o >= 65536) begin
        tgt = 3; own = 1; dtag = "R12";
        if (fo == 'h80) begin d = 32'hFFFF_FFFF; dtag = "R10"; end
        else if (fo == 'h300 || fo == 'h380 || fo == 'hD00 || fo == 'hE00) dtag = "R10";
        else if (fo == 'h100 || fo == 'h180 || fo == 'h200 || fo == 'h280 ||
                 (fo >= 'h400 && fo < 'h420) || (fo >= 'hC00 && fo < 'hC08)) begin
          own = 0; dtag = "R11";
        end
      end else begin
        tgt = 2; own = 1; dtag = "R12";
        if (fo == 4) begin d = IDENT; dtag = "R9"; end
        else if (fo == 8) begin
          d = 32'(cpu * 256 + ((cpu == n - 1) ? 16 : 0)); dtag = "R6";
        end else if (fo == 12) begin
          logic [39:0] id = cpu_ident[cpu];
          d = {id[39:32], id[23:16], id[15:8], id[7:0]}; dtag = "R7";
        end else if (fo == 0 || fo == 'h14) dtag = "R8";
        else if (fo == 'hFFE8) begin d = 32'h3B; dtag = "R9"; end
        else if (fo >= 'hFFD0) dtag = "R9";
      end
    end else if (a >= RB && a < RB + longint'(MAXC + 2) * FR) begin
      ttag = "R3"; dtag = "R3";
    end
    if (wr) begin d = 0; dtag = "R8"; end
  endfunction

  // cycle model state
  bit m_valid = 0;
  int m_tgt, m_cpu;
  bit m_own;
  logic [31:0] m_data;
  string m_ttag, m_dtag;

  always @(posedge clk) begin
    if (!rst_n) m_valid = 0;
    else begin
      bit m_ready = !m_valid || rsp_ready;
      if (req_valid && m_ready) begin
        model(req_addr, req_write, int'(online_cnt), m_tgt, m_cpu, m_own, m_data, m_ttag, m_dtag);
        m_valid = 1;
      end else if (rsp_ready) m_valid = 0;
    end
  end

  task automatic miss(input string tag, input string what, input longint act, input longint exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (rsp_valid !== m_valid) miss("R13", "rsp_valid", longint'(rsp_valid), longint'(m_valid));
      if (req_ready !== (!m_valid || rsp_ready))
        miss("R13", "req_ready", longint'(req_ready), longint'(!m_valid || rsp_ready));
      if (m_valid && rsp_valid === 1'b1) begin
        if (int'(rsp_target) != m_tgt) miss(m_ttag, "target", longint'(rsp_target), longint'(m_tgt));
        if (int'(rsp_cpu) != m_cpu) miss("R4", "cpu", longint'(rsp_cpu), longint'(m_cpu));
        if (rsp_owned !== m_own) miss(m_dtag, "owned", longint'(rsp_owned), longint'(m_own));
        if (rsp_rdata !== m_data) miss(m_dtag, "rdata", longint'(rsp_rdata), longint'(m_data));
      end
    end
  end

  // consumer back-pressure
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_ready = stall_mode ? lfsr[0] : 1'b1;
    end
  end

  task automatic send(input longint a, input bit wr);
    bit acc;
    req_valid = 1; req_addr = 32'(a); req_write = wr;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    $display("FAIL watchdog expired");
    fails++;
    finish_run();
  end

  initial begin
    for (int i = 0; i < MAXC; i++)
      cpu_ident[i] = {8'(8'hA0 + i), 8'h5A, 8'(8'h10 + i), 8'(8'h20 + i), 8'(8'h30 + i)};
    idle(3);
    rst_n = 1;                 // reset state checked by the per-cycle compare (R13)
    idle(2);
    // R1 distributor window edges
    send(DB, 0); send(DB + 'h1234, 0); send(DB + DS - 4, 0);
    // R2 unclaimed
    send(0, 0); send(DB + DS, 0); send(RB - 4, 0); send(32'hFFFF_FFFC, 0);
    // R4 R6 R7 R8 R9 R12 control half of each processor
    for (int c = 0; c < 4; c++) begin
      longint b = RB + c * FR;
      send(b + 'h8, 0); send(b + 'hC, 0); send(b + 'h4, 0); send(b + 'h0, 0);
      send(b + 'h14, 0); send(b + 'hFFE8, 0); send(b + 'hFFD0, 0); send(b + 'hFFFC, 0);
      send(b + 'h40, 0); send(b + 'hB, 0);
    end
    // R5 R10 R11 R12 private half
    for (int c = 0; c < 4; c++) begin
      longint p = RB + c * FR + 65536;
      send(p, 0); send(p + 'h80, 0); send(p + 'h300, 0); send(p + 'h380, 0);
      send(p + 'hD00, 0); send(p + 'hE00, 0); send(p + 'h100, 0); send(p + 'h180, 0);
      send(p + 'h200, 0); send(p + 'h280, 0); send(p + 'h400, 0); send(p + 'h41C, 0);
      send(p + 'h420, 0); send(p + 'hC04, 0); send(p + 'hC08, 0); send(p + 'hFFE8, 0);
    end
    // R3 window end moves with online count
    send(RB + 4 * FR, 0); send(RB + 4 * FR - 4, 0);
    online_cnt = 2;
    send(RB + FR + 8, 0); send(RB + 8, 0); send(RB + 2 * FR, 0);
    online_cnt = 0;
    send(RB, 0); send(RB + 65536 + 'h80, 0);
    online_cnt = 15;           // clamped to MAX_CPUS
    send(RB + 7 * FR + 8, 0); send(RB + 7 * FR + 'hC, 0); send(RB + 8 * FR, 0);
    online_cnt = 4;
    // R8 writes ignored
    send(RB + FR + 8, 1); send(RB + FR + 8, 0);
    send(RB + 'h0, 1); send(RB + 'h0, 0);
    send(RB + 65536 + 'h80, 1); send(RB + 65536 + 'h80, 0);
    send(DB + 4, 1);
    // R13 back-to-back under stalls
    stall_mode = 1;
    for (int k = 0; k < 200; k++) begin
      longint sel = k % 7;
      longint c = (k / 7) % 5;
      if (sel == 0) send(RB + c * FR + 8, 0);
      else if (sel == 1) send(RB + c * FR + 'hC, k % 3 == 0);
      else if (sel == 2) send(RB + c * FR + 65536 + 'h80, 0);
      else if (sel == 3) send(RB + c * FR + 65536 + 'h200, 0);
      else if (sel == 4) send(DB + c * 16, 0);
      else if (sel == 5) send(RB + c * FR + 'hFFE8, 0);
      else send(RB - 8 * c - 4, 0);
    end
    stall_mode = 0;
    idle(6);
    finish_run();
  end

endmodule